// File: doc/BRIEF.md
# USB Full-Speed Transmit Line Encoder

This block turns a serial packet stream into the line signals of a full-speed USB transceiver. The processor side shifts out SYNC, PID, address or payload bits one at a time. An external CRC unit shifts out its check bits on a second serial input. The encoder places the CRC bits over the CRC field of the packet. It inserts a zero after every run of six ones and NRZI-encodes the stream. It drives the data, SE0 and output-enable lines, and closes the packet with an end-of-packet pattern.

The packet type is taken from the second PID bit on the wire. A bit counter is cleared at start of packet and decides which bits come from the CRC input. For a token the decision depends only on the bit position. For a data packet the processor raises `finished_i` once its last payload bit has been taken. The counter is cleared again at that point, and the next sixteen bits come from the CRC input. One clock cycle is one bit time.

Top module: `usbfs_tx_encoder`

## Requirements
- R1: While idle, `oe_o`=0, `se0_o`=0 and `dat_o`=1 (J). A `sop_i` pulse during a packet has no effect on that packet.
- R2: A `sop_i` pulse while idle makes `oe_o`=1 with `dat_o`=1 from the next cycle on. From that cycle, `bit_req_o` is high in every cycle that takes a stream bit; the bit taken is bit index 0, 1, 2 and so on (SYNC first).
- R3: Each bit placed on the line is shown on `dat_o` one cycle after it is taken. A 0 toggles `dat_o` and a 1 holds it.
- R4: After six consecutive ones on the line (counted from start of packet, CRC bits included), the next cycle sends a stuffed 0. In that cycle `bit_req_o`=0 and `crc_shift_o`=0. This also holds after the last CRC bit.
- R5: Stream bit index 9 (the second PID bit sent) selects the packet type: 0 is a token and 1 is a data packet.
- R6: In a token, bit indices 27 to 31 are taken from `crc_bit_i`, with `crc_shift_o`=1. The `tx_bit_i` value in those positions is ignored.
- R7: A token's end-of-packet begins right after bit index 31, or right after a stuffed bit that follows it.
- R8: In a data packet, the cycle in which `finished_i` is first seen high, and the following bits up to sixteen in total, are taken from `crc_bit_i`. End-of-packet follows at once.
- R9: End-of-packet drives `se0_o`=1 for two cycles. Then comes one cycle of `se0_o`=0, `dat_o`=1 with `oe_o`=1. After that, `oe_o`=0.
- R10: `finished_i` has no effect on a token.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sop_i | input | 1 | Start-of-packet request pulse |
| tx_bit_i | input | 1 | Next stream bit from the processor shift register |
| finished_i | input | 1 | Level; rises when the data payload is exhausted |
| crc_bit_i | input | 1 | Next CRC bit from the CRC unit |
| bit_req_o | output | 1 | Processor stream bit consumed this cycle |
| crc_shift_o | output | 1 | CRC bit consumed this cycle |
| oe_o | output | 1 | Transceiver output enable |
| dat_o | output | 1 | NRZI line data (1 = J) |
| se0_o | output | 1 | Drive single-ended zero |

## Verification
A wrong bit counter or packet-type latch shows up on the CRC-fetch strobe and on the line data. The effect is visible in the first cycle in which a CRC bit is taken too early or too late, and end-of-packet then starts at the wrong position. A wrong run-of-ones count moves a stuffed bit. This shows at once as a low bit request in the wrong cycle and one cycle later as a missing or extra NRZI toggle. A wrong line state shows as a mismatch in the SE0 or output-enable timing within the four cycles that end a packet.

// File: rtl/usbfs_tx_pkg.sv
package usbfs_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BODY,
    ST_SE0A,
    ST_SE0B,
    ST_JEND
  } tx_state_e;

endpackage

// File: rtl/usbfs_tx_bitcount.sv
module usbfs_tx_bitcount #(
  parameter int TOKEN_CRC_AT  = 27,
  parameter int TOKEN_CRC_LEN = 5,
  parameter int DATA_CRC_LEN  = 16,
  parameter int TYPE_BIT      = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic active_i,
  input  logic consume_i,
  input  logic raw_bit_i,
  input  logic finished_i,
  output logic crc_sel_o,
  output logic done_o
);

  localparam int TOKEN_END = TOKEN_CRC_AT + TOKEN_CRC_LEN;
  localparam int CNT_W     = $clog2(TOKEN_END + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_eff;
  logic             is_data_q, is_data_d;
  logic             known_q, known_d;
  logic             fin_mode_q, fin_mode_d;
  logic             fin_q;
  logic             fin_rise;

  always_comb begin
    fin_rise = active_i && known_q && is_data_q && finished_i && !fin_q && !fin_mode_q;
    cnt_eff  = fin_rise ? '0 : cnt_q;

    if (!known_q)
      crc_sel_o = 1'b0;
    else if (is_data_q)
      crc_sel_o = fin_mode_q || fin_rise;
    else
      crc_sel_o = (cnt_eff >= CNT_W'(TOKEN_CRC_AT)) && (cnt_eff < CNT_W'(TOKEN_END));

    if (!known_q)
      done_o = 1'b0;
    else if (is_data_q)
      done_o = fin_mode_q && (cnt_q == CNT_W'(DATA_CRC_LEN));
    else
      done_o = (cnt_q == CNT_W'(TOKEN_END));

    cnt_d      = cnt_eff;
    is_data_d  = is_data_q;
    known_d    = known_q;
    fin_mode_d = fin_mode_q || fin_rise;
    if (consume_i) begin
      cnt_d = (cnt_eff == CNT_MAX) ? cnt_eff : cnt_eff + 1'b1;
      if (!known_q && cnt_eff == CNT_W'(TYPE_BIT)) begin
        is_data_d = raw_bit_i;
        known_d   = 1'b1;
      end
    end
    if (start_i) begin
      cnt_d      = '0;
      is_data_d  = 1'b0;
      known_d    = 1'b0;
      fin_mode_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      is_data_q  <= 1'b0;
      known_q    <= 1'b0;
      fin_mode_q <= 1'b0;
      fin_q      <= 1'b0;
    end else begin
      cnt_q      <= cnt_d;
      is_data_q  <= is_data_d;
      known_q    <= known_d;
      fin_mode_q <= fin_mode_d;
      fin_q      <= finished_i;
    end
  end

  // R10: a token never enters CRC-after-finish mode
  p_token_no_fin_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (known_q && !is_data_q) |-> !fin_mode_q);

  // R7: token count never runs past the end of its CRC field
  p_token_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (known_q && !is_data_q) |-> (cnt_q <= CNT_W'(TOKEN_END)));

  // R8: data CRC count never runs past its length
  p_data_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fin_mode_q |-> (cnt_q <= CNT_W'(DATA_CRC_LEN)));

endmodule

// File: rtl/usbfs_tx_stuffer.sv
module usbfs_tx_stuffer #(
  parameter int RUN = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic active_i,
  input  logic consume_i,
  input  logic raw_bit_i,
  output logic stuff_o
);

  localparam int ONES_W = $clog2(RUN + 1);

  logic [ONES_W-1:0] ones_q, ones_d;

  always_comb begin
    stuff_o = active_i && (ones_q == ONES_W'(RUN));
    ones_d  = ones_q;
    if (start_i || stuff_o)
      ones_d = '0;
    else if (consume_i)
      ones_d = raw_bit_i ? ones_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ones_q <= '0;
    else        ones_q <= ones_d;
  end

  // R4: run length never exceeds the stuffing limit
  p_run_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ones_q <= ONES_W'(RUN));

  // R4: never two stuffed bits in a row
  p_single_stuff_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_o |=> !stuff_o);

endmodule

// File: rtl/usbfs_tx_line.sv
module usbfs_tx_line
  import usbfs_tx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sop_i,
  input  logic stuff_i,
  input  logic done_i,
  input  logic raw_bit_i,
  output logic start_o,
  output logic active_o,
  output logic consume_o,
  output logic dat_o,
  output logic se0_o,
  output logic oe_o
);

  tx_state_e state_q, state_d;
  logic      nrzi_q, nrzi_d;
  logic      se0_q, se0_d;
  logic      oe_q, oe_d;
  logic      eop_go;

  always_comb begin
    start_o   = (state_q == ST_IDLE) && sop_i;
    active_o  = (state_q == ST_BODY);
    consume_o = active_o && !stuff_i && !done_i;
    eop_go    = active_o && done_i && !stuff_i;

    state_d = state_q;
    nrzi_d  = nrzi_q;
    unique case (state_q)
      ST_IDLE: if (sop_i) begin
        state_d = ST_BODY;
        nrzi_d  = 1'b1;
      end
      ST_BODY: begin
        if (stuff_i)        nrzi_d  = ~nrzi_q;
        else if (consume_o) nrzi_d  = raw_bit_i ? nrzi_q : ~nrzi_q;
        if (eop_go)         state_d = ST_SE0A;
      end
      ST_SE0A: state_d = ST_SE0B;
      ST_SE0B: begin
        state_d = ST_JEND;
        nrzi_d  = 1'b1;
      end
      ST_JEND: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase

    oe_d  = (state_d != ST_IDLE);
    se0_d = (state_d == ST_SE0A) || (state_d == ST_SE0B);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      nrzi_q  <= 1'b1;
      se0_q   <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      nrzi_q  <= nrzi_d;
      se0_q   <= se0_d;
      oe_q    <= oe_d;
    end
  end

  assign dat_o = nrzi_q;
  assign se0_o = se0_q;
  assign oe_o  = oe_q;

  // R1: released line rests in J
  p_idle_j_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_o |-> (dat_o && !se0_o));

  // R3: a stuffed zero always toggles the line
  p_stuff_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && stuff_i) |=> (dat_o != $past(dat_o)));

  // R9: SE0 lasts at least two bit times
  p_se0_two_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(se0_o) |=> se0_o);

  // R9: two SE0 bits are followed by a driven J
  p_se0_then_j_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (se0_o && $past(se0_o)) |=> (!se0_o && dat_o && oe_o));

endmodule

// File: rtl/usbfs_tx_encoder.sv
module usbfs_tx_encoder #(
  parameter int TOKEN_CRC_AT  = 27,
  parameter int TOKEN_CRC_LEN = 5,
  parameter int DATA_CRC_LEN  = 16,
  parameter int TYPE_BIT      = 9,
  parameter int STUFF_RUN     = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sop_i,
  input  logic tx_bit_i,
  input  logic finished_i,
  input  logic crc_bit_i,
  output logic bit_req_o,
  output logic crc_shift_o,
  output logic oe_o,
  output logic dat_o,
  output logic se0_o
);

  logic start, active, consume, stuff, done, crc_sel, raw_bit;

  assign raw_bit     = crc_sel ? crc_bit_i : tx_bit_i;
  assign bit_req_o   = consume;
  assign crc_shift_o = consume && crc_sel;

  usbfs_tx_bitcount #(
    .TOKEN_CRC_AT (TOKEN_CRC_AT),
    .TOKEN_CRC_LEN(TOKEN_CRC_LEN),
    .DATA_CRC_LEN (DATA_CRC_LEN),
    .TYPE_BIT     (TYPE_BIT)
  ) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start),
    .active_i  (active),
    .consume_i (consume),
    .raw_bit_i (raw_bit),
    .finished_i(finished_i),
    .crc_sel_o (crc_sel),
    .done_o    (done)
  );

  usbfs_tx_stuffer #(
    .RUN(STUFF_RUN)
  ) u_stuff (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start),
    .active_i (active),
    .consume_i(consume),
    .raw_bit_i(raw_bit),
    .stuff_o  (stuff)
  );

  usbfs_tx_line u_line (
    .clk      (clk),
    .rst_n    (rst_n),
    .sop_i    (sop_i),
    .stuff_i  (stuff),
    .done_i   (done),
    .raw_bit_i(raw_bit),
    .start_o  (start),
    .active_o (active),
    .consume_o(consume),
    .dat_o    (dat_o),
    .se0_o    (se0_o),
    .oe_o     (oe_o)
  );

  // R4: a CRC fetch is always also a stream consumption
  p_crc_is_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    crc_shift_o |-> bit_req_o);

  // R2: no stream bit is requested while the line is released
  p_req_needs_oe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_req_o |-> oe_o);

endmodule

// File: tb/usbfs_tx_encoder_tb.sv
module usbfs_tx_encoder_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sop_i = 1'b0, tx_bit_i = 1'b0, finished_i = 1'b0, crc_bit_i = 1'b0;
  logic bit_req_o, crc_shift_o, oe_o, dat_o, se0_o;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  bit procq[$];
  bit crcq[$];

  always #4 clk = ~clk;

  usbfs_tx_encoder u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .sop_i      (sop_i),
    .tx_bit_i   (tx_bit_i),
    .finished_i (finished_i),
    .crc_bit_i  (crc_bit_i),
    .bit_req_o  (bit_req_o),
    .crc_shift_o(crc_shift_o),
    .oe_o       (oe_o),
    .dat_o      (dat_o),
    .se0_o      (se0_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic push_bits(input string s, input bit to_crc);
    for (int k = 0; k < s.len(); k++) begin
      if (to_crc) crcq.push_back(s[k] == 8'h31);
      else        procq.push_back(s[k] == 8'h31);
    end
  endtask

  // Sends procq/crcq as one packet and compares every cycle.
  // fin_at: token only, processor bit count at which finished_i is raised (-1 none)
  // glitch_at: slot at which a stray sop_i pulse is applied (-1 none)
  task automatic send_packet(input bit is_data, input int fin_at, input int glitch_at,
                             input string tag);
    int slot_v[$];
    bit slot_c[$];
    int ones = 0;
    int nraw;
    int p = 0, q = 0;
    bit nrzi = 1'b1;
    bit v;
    bit isc;
    nraw = is_data ? procq.size() + crcq.size() : 27 + crcq.size();
    for (int j = 0; j < nraw; j++) begin
      if (is_data) begin
        isc = (j >= procq.size());
        v   = isc ? crcq[j - procq.size()] : procq[j];
      end else begin
        isc = (j >= 27);
        v   = isc ? crcq[j - 27] : procq[j];
      end
      slot_v.push_back(int'(v));
      slot_c.push_back(isc);
      ones = v ? ones + 1 : 0;
      if (ones == 6) begin
        slot_v.push_back(2);
        slot_c.push_back(1'b0);
        ones = 0;
      end
    end

    @(negedge clk);
    sop_i = 1'b1;
    for (int i = 0; i < slot_v.size(); i++) begin
      @(negedge clk);
      sop_i = (i == glitch_at);
      if (is_data && p == procq.size()) finished_i = 1'b1;
      if (!is_data && fin_at >= 0 && p == fin_at) finished_i = 1'b1;
      #1;
      if (i == 0) chk({tag, " R2 sop gives J with oe"}, {oe_o, dat_o}, 2'b11);
      chk({tag, " R1/R2 oe held in packet"}, oe_o, 1);
      chk({tag, " R9 no se0 in body"}, se0_o, 0);
      chk({tag, " R3 nrzi line"}, dat_o, nrzi);
      chk({tag, " R4/R2 bit request"}, bit_req_o, slot_v[i] != 2);
      chk({tag, is_data ? " R8 crc fetch" : " R6 crc fetch"}, crc_shift_o,
          (slot_v[i] != 2) && slot_c[i]);
      tx_bit_i  = (p < procq.size()) ? procq[p] : 1'b1;
      crc_bit_i = (q < crcq.size()) ? crcq[q] : 1'b0;
      if (bit_req_o)   p++;
      if (crc_shift_o) q++;
      if (slot_v[i] != 1) nrzi = ~nrzi;
    end
    sop_i = 1'b0;
    @(negedge clk); #1;
    chk({tag, " R3 last bit on line"}, dat_o, nrzi);
    chk({tag, is_data ? " R8 no request at end" : " R7 no request at end"}, bit_req_o, 0);
    chk({tag, " R7/R8 eop not yet"}, se0_o, 0);
    @(negedge clk); #1;
    chk({tag, " R9 se0 first"}, {oe_o, se0_o}, 2'b11);
    @(negedge clk); #1;
    chk({tag, " R9 se0 second"}, {oe_o, se0_o}, 2'b11);
    @(negedge clk); #1;
    chk({tag, " R9 driven J"}, {oe_o, se0_o, dat_o}, 3'b101);
    @(negedge clk); #1;
    chk({tag, " R9/R1 released"}, {oe_o, se0_o, dat_o}, 3'b001);
    chk({tag, " R10/R8 all crc taken"}, q, crcq.size());
    finished_i = 1'b0;
    procq.delete();
    crcq.delete();
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset idle", {oe_o, se0_o, dat_o, bit_req_o, crc_shift_o}, 5'b00100);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk("R1 idle after reset", {oe_o, se0_o, dat_o}, 3'b001);

    // Token: address all ones, zero placeholders, CRC 10110 (R5 token, R6, R7)
    push_bits("00000001", 0);
    push_bits("10010110", 0);
    push_bits("11111111111", 0);
    push_bits("00000", 0);
    push_bits("10110", 1);
    send_packet(1'b0, -1, -1, "tok1");

    // Token: nonzero placeholders ignored, finished raised (R10), stray sop (R1),
    // CRC run causes stuffing inside the CRC field (R4)
    push_bits("00000001", 0);
    push_bits("10010110", 0);
    push_bits("10100100111", 0);
    push_bits("11111", 0);
    push_bits("11111", 1);
    send_packet(1'b0, 20, 15, "tok2");

    // Data packet with a stuffed bit in payload and CRC (R5 data, R8)
    push_bits("00000001", 0);
    push_bits("11000011", 0);
    push_bits("1011001011111110", 0);
    push_bits("0110100111111101", 1);
    send_packet(1'b1, -1, -1, "dat1");

    // Data packet: finish coincides with a stuffed bit, stuff after last CRC bit (R4, R8)
    push_bits("00000001", 0);
    push_bits("11000011", 0);
    push_bits("00111111", 0);
    push_bits("0000111111111111", 1);
    send_packet(1'b1, -1, -1, "dat2");

    // Zero-length data packet: finished seen at first payload position (R8)
    push_bits("00000001", 0);
    push_bits("11010010", 0);
    push_bits("1000000000000001", 1);
    send_packet(1'b1, -1, -1, "dat3");

    repeat (2) @(negedge clk);
    #1;
    chk("R1 idle between packets", {oe_o, se0_o, dat_o}, 3'b001);
    finish_run();
  end

endmodule